// File: doc/BRIEF.md
# Post-Modify Address Pointer Unit

This block keeps a small set of address pointers, each paired with a step register. An access names one pointer, and the block drives that pointer's current value out as an address. In the same cycle it moves the pointer by a signed step taken from the paired step register. Each step register is split into four 4-bit step fields. Two fields serve source accesses and two serve destination accesses. As a result, one pointer can advance by different amounts depending on the access direction.

There are three access kinds. A source access selects a pointer and one of its two source fields. A destination access selects a pointer and one of its two destination fields. A dual access reads two pointers together: pointer 0 or 1 on the first address output, and the last pointer on the second output. Both are updated in the same cycle. Pointers and step registers can also be loaded with full 16-bit values. A set-field command writes a 4-bit immediate into one field of one step register and leaves the other fields unchanged.

Top module: `postmod_ptr_unit`

## Requirements
- R1: Synchronous active-high reset clears every pointer, every step register, both address outputs and both valid flags.
- R2: With `acc_mode`=01 (source), pointer `acc_sel[1:0]` appears on `addr_a` with `addr_a_vld` high one cycle later. The pointer then moves by its step field S (`acc_sel[2]`=0: step bits 3:0, `acc_sel[2]`=1: step bits 7:4).
- R3: With `acc_mode`=10 (destination), the access behaves as in R2, except that `acc_sel[2]`=0 selects step bits 11:8 and `acc_sel[2]`=1 selects step bits 15:12.
- R4: Each 4-bit step field is a two's-complement value from -8 to +7. It is sign-extended before the add, and the pointer wraps modulo 2^16.
- R5: With `acc_mode`=11 (dual), the first access works as follows: `acc_sel[0]` picks pointer 0 or 1 and `acc_sel[1]` picks step bits 3:0 or 7:4; the result goes out on `addr_a`. The second access uses the last pointer, with `acc_sel[2]` picking step bits 3:0 or 7:4; the result goes out on `addr_b` with `addr_b_vld` high. Both pointers update in the same cycle. `addr_b_vld` is low after any other mode.
- R6: A set-field command writes `fld_imm` into one field of step register `fld_idx`, chosen by `fld_code`: 00 = bits 3:0, 01 = bits 7:4, 10 = bits 11:8, 11 = bits 15:12. All other bits of that register keep their values.
- R7: A full load writes `ptr_ld_val` into pointer `ptr_ld_idx`, or `step_ld_val` into step register `step_ld_idx`. A full step load wins over a set-field command to the same register in the same cycle.
- R8: A full pointer load in the same cycle as a post-modify of that pointer wins over the post-modify. The address output still shows the value from before the load.
- R9: With `acc_mode`=00 (idle), both valid flags are low and no pointer changes unless it is loaded. Pointers that are not selected never change.
- R10: A post-modify uses the step value held before any step write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_mode | input | 2 | 00 idle, 01 source, 10 destination, 11 dual |
| acc_sel | input | 3 | Pointer and step-field select, decoded per mode |
| ptr_ld_en | input | 1 | Full pointer load enable |
| ptr_ld_idx | input | 2 | Pointer to load |
| ptr_ld_val | input | 16 | Pointer load value |
| step_ld_en | input | 1 | Full step register load enable |
| step_ld_idx | input | 2 | Step register to load |
| step_ld_val | input | 16 | Step register load value |
| fld_en | input | 1 | Set-field enable |
| fld_idx | input | 2 | Step register for set-field |
| fld_code | input | 2 | Field to write |
| fld_imm | input | 4 | Immediate field value |
| addr_a | output | 16 | First access address (pre-update pointer) |
| addr_a_vld | output | 1 | `addr_a` holds a fresh address |
| addr_b | output | 16 | Dual-mode second address |
| addr_b_vld | output | 1 | `addr_b` holds a fresh address |
| ptr_flat | output | 64 | All pointers, pointer n at bits 16n+15:16n |
| step_flat | output | 64 | All step registers, register n at bits 16n+15:16n |

## Verification
The assertions check the following on every cycle. The valid flags follow the access mode. A source or destination access returns the old pointer and leaves that pointer at the old value plus the sign-extended chosen field. The dual second address always comes from the last pointer. A pointer load always lands, and idle pointers stay still. A set-field never touches bits outside its field. Only the bench's scenarios show the outcomes that need several cycles: pointer wrap across zero, negative steps of -1 and -8, a dual access updating two pointers at once, the step value used when a step write lands in the same cycle, and a full step load beating a set-field.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

  // Access kinds presented on acc_mode
  typedef enum logic [1:0] {
    ACC_IDLE = 2'b00,
    ACC_SRC  = 2'b01,
    ACC_DST  = 2'b10,
    ACC_DUAL = 2'b11
  } acc_mode_e;

  // Step field codes; position in the step register is code * field width
  typedef enum logic [1:0] {
    FLD_S0 = 2'b00,
    FLD_S1 = 2'b01,
    FLD_D0 = 2'b10,
    FLD_D1 = 2'b11
  } fld_e;

endpackage

// File: rtl/pmp_sel_decode.sv
module pmp_sel_decode
  import pmp_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic [1:0]       mode,
  input  logic [IDX_W:0]   sel,
  output logic             a_vld,
  output logic [IDX_W-1:0] a_ptr,
  output fld_e             a_fld,
  output logic             b_vld,
  output logic [IDX_W-1:0] b_ptr,
  output fld_e             b_fld
);

  always_comb begin
    a_vld = 1'b0;
    a_ptr = sel[IDX_W-1:0];
    a_fld = FLD_S0;
    b_vld = 1'b0;
    b_ptr = '1;
    b_fld = FLD_S0;
    case (acc_mode_e'(mode))
      ACC_SRC: begin
        a_vld = 1'b1;
        a_fld = sel[IDX_W] ? FLD_S1 : FLD_S0;
      end
      ACC_DST: begin
        a_vld = 1'b1;
        a_fld = sel[IDX_W] ? FLD_D1 : FLD_D0;
      end
      ACC_DUAL: begin
        // reduced selects: pointer 0/1 on port A, last pointer on port B
        a_vld = 1'b1;
        a_ptr = IDX_W'(sel[0]);
        a_fld = sel[1] ? FLD_S1 : FLD_S0;
        b_vld = 1'b1;
        b_fld = sel[IDX_W] ? FLD_S1 : FLD_S0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pmp_step_ext.sv
module pmp_step_ext
  import pmp_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int NPTR  = 4,
  parameter int IDX_W = 2
) (
  input  logic [NPTR-1:0][PTR_W-1:0] steps,
  input  logic [IDX_W-1:0]           idx,
  input  fld_e                       fld,
  output logic [PTR_W-1:0]           inc
);

  localparam int FLD_W = PTR_W / 4;

  logic [PTR_W-1:0] step_sel;
  logic [FLD_W-1:0] raw;

  always_comb begin
    step_sel = steps[idx];
    raw      = step_sel[FLD_W*int'(fld) +: FLD_W];
    inc      = {{(PTR_W-FLD_W){raw[FLD_W-1]}}, raw};
  end

endmodule

// File: rtl/pmp_step_file.sv
module pmp_step_file #(
  parameter int PTR_W = 16,
  parameter int NPTR  = 4,
  parameter int IDX_W = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ld_en,
  input  logic [IDX_W-1:0]           ld_idx,
  input  logic [PTR_W-1:0]           ld_val,
  input  logic                       sf_en,
  input  logic [IDX_W-1:0]           sf_idx,
  input  logic [1:0]                 sf_code,
  input  logic [PTR_W/4-1:0]         sf_imm,
  output logic [NPTR-1:0][PTR_W-1:0] steps
);

  localparam int FLD_W = PTR_W / 4;

  logic [NPTR-1:0][PTR_W-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
    end else begin
      for (int i = 0; i < NPTR; i++) begin
        if (ld_en && ld_idx == IDX_W'(i)) begin
          step_q[i] <= ld_val;
        end else if (sf_en && sf_idx == IDX_W'(i)) begin
          step_q[i][FLD_W*int'(sf_code) +: FLD_W] <= sf_imm;
        end
      end
    end
  end

  assign steps = step_q;

endmodule

// File: rtl/pmp_ptr_file.sv
module pmp_ptr_file #(
  parameter int PTR_W = 16,
  parameter int NPTR  = 4,
  parameter int IDX_W = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ld_en,
  input  logic [IDX_W-1:0]           ld_idx,
  input  logic [PTR_W-1:0]           ld_val,
  input  logic                       a_vld,
  input  logic [IDX_W-1:0]           a_ptr,
  input  logic [PTR_W-1:0]           a_inc,
  input  logic                       b_vld,
  input  logic [IDX_W-1:0]           b_ptr,
  input  logic [PTR_W-1:0]           b_inc,
  output logic [NPTR-1:0][PTR_W-1:0] ptrs
);

  logic [NPTR-1:0][PTR_W-1:0] ptr_q;

  // Load beats post-modify; port A and port B never share a pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else begin
      for (int i = 0; i < NPTR; i++) begin
        if (ld_en && ld_idx == IDX_W'(i)) begin
          ptr_q[i] <= ld_val;
        end else if (a_vld && a_ptr == IDX_W'(i)) begin
          ptr_q[i] <= ptr_q[i] + a_inc;
        end else if (b_vld && b_ptr == IDX_W'(i)) begin
          ptr_q[i] <= ptr_q[i] + b_inc;
        end
      end
    end
  end

  assign ptrs = ptr_q;

endmodule

// File: rtl/postmod_ptr_unit.sv
module postmod_ptr_unit
  import pmp_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int NPTR  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              acc_mode,
  input  logic [$clog2(NPTR):0]   acc_sel,
  input  logic                    ptr_ld_en,
  input  logic [$clog2(NPTR)-1:0] ptr_ld_idx,
  input  logic [PTR_W-1:0]        ptr_ld_val,
  input  logic                    step_ld_en,
  input  logic [$clog2(NPTR)-1:0] step_ld_idx,
  input  logic [PTR_W-1:0]        step_ld_val,
  input  logic                    fld_en,
  input  logic [$clog2(NPTR)-1:0] fld_idx,
  input  logic [1:0]              fld_code,
  input  logic [PTR_W/4-1:0]      fld_imm,
  output logic [PTR_W-1:0]        addr_a,
  output logic                    addr_a_vld,
  output logic [PTR_W-1:0]        addr_b,
  output logic                    addr_b_vld,
  output logic [NPTR*PTR_W-1:0]   ptr_flat,
  output logic [NPTR*PTR_W-1:0]   step_flat
);

  localparam int IDX_W = $clog2(NPTR);
  localparam int NPORT = 2;

  logic [NPTR-1:0][PTR_W-1:0] ptrs;
  logic [NPTR-1:0][PTR_W-1:0] steps;

  logic [NPORT-1:0]            p_vld;
  logic [NPORT-1:0][IDX_W-1:0] p_ptr;
  fld_e                        p_fld [NPORT];
  logic [NPORT-1:0][PTR_W-1:0] p_inc;

  pmp_sel_decode #(.IDX_W(IDX_W)) u_dec (
    .mode  (acc_mode),
    .sel   (acc_sel),
    .a_vld (p_vld[0]),
    .a_ptr (p_ptr[0]),
    .a_fld (p_fld[0]),
    .b_vld (p_vld[1]),
    .b_ptr (p_ptr[1]),
    .b_fld (p_fld[1])
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    pmp_step_ext #(.PTR_W(PTR_W), .NPTR(NPTR), .IDX_W(IDX_W)) u_ext (
      .steps (steps),
      .idx   (p_ptr[g]),
      .fld   (p_fld[g]),
      .inc   (p_inc[g])
    );
  end

  pmp_step_file #(.PTR_W(PTR_W), .NPTR(NPTR), .IDX_W(IDX_W)) u_steps (
    .clk     (clk),
    .rst     (rst),
    .ld_en   (step_ld_en),
    .ld_idx  (step_ld_idx),
    .ld_val  (step_ld_val),
    .sf_en   (fld_en),
    .sf_idx  (fld_idx),
    .sf_code (fld_code),
    .sf_imm  (fld_imm),
    .steps   (steps)
  );

  pmp_ptr_file #(.PTR_W(PTR_W), .NPTR(NPTR), .IDX_W(IDX_W)) u_ptrs (
    .clk    (clk),
    .rst    (rst),
    .ld_en  (ptr_ld_en),
    .ld_idx (ptr_ld_idx),
    .ld_val (ptr_ld_val),
    .a_vld  (p_vld[0]),
    .a_ptr  (p_ptr[0]),
    .a_inc  (p_inc[0]),
    .b_vld  (p_vld[1]),
    .b_ptr  (p_ptr[1]),
    .b_inc  (p_inc[1]),
    .ptrs   (ptrs)
  );

  // Registered address outputs carry the pre-update pointer value
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_a     <= '0;
      addr_a_vld <= 1'b0;
      addr_b     <= '0;
      addr_b_vld <= 1'b0;
    end else begin
      addr_a_vld <= p_vld[0];
      addr_b_vld <= p_vld[1];
      if (p_vld[0]) addr_a <= ptrs[p_ptr[0]];
      if (p_vld[1]) addr_b <= ptrs[p_ptr[1]];
    end
  end

  assign ptr_flat  = ptrs;
  assign step_flat = steps;

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker #(
  parameter int PTR_W = 16,
  parameter int NPTR  = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic [1:0]              acc_mode,
  input logic [$clog2(NPTR):0]   acc_sel,
  input logic                    ptr_ld_en,
  input logic [$clog2(NPTR)-1:0] ptr_ld_idx,
  input logic [PTR_W-1:0]        ptr_ld_val,
  input logic                    step_ld_en,
  input logic [$clog2(NPTR)-1:0] step_ld_idx,
  input logic [PTR_W-1:0]        step_ld_val,
  input logic                    fld_en,
  input logic [$clog2(NPTR)-1:0] fld_idx,
  input logic [1:0]              fld_code,
  input logic [PTR_W/4-1:0]      fld_imm,
  input logic [PTR_W-1:0]        addr_a,
  input logic                    addr_a_vld,
  input logic [PTR_W-1:0]        addr_b,
  input logic                    addr_b_vld,
  input logic [NPTR*PTR_W-1:0]   ptr_flat,
  input logic [NPTR*PTR_W-1:0]   step_flat
);

  localparam int IDX_W = $clog2(NPTR);
  localparam int FLD_W = PTR_W / 4;

  logic [PTR_W-1:0] ptr_w  [NPTR];
  logic [PTR_W-1:0] step_w [NPTR];
  logic [IDX_W-1:0] s_idx;
  logic [1:0]       s_code;
  logic [FLD_W-1:0] s_raw;
  logic [PTR_W-1:0] s_next;
  logic [PTR_W-1:0] s_now;
  logic [PTR_W-1:0] f_mask;
  logic             s_ld_hit;

  always_comb begin
    for (int i = 0; i < NPTR; i++) begin
      ptr_w[i]  = ptr_flat[i*PTR_W +: PTR_W];
      step_w[i] = step_flat[i*PTR_W +: PTR_W];
    end
    s_idx    = acc_sel[IDX_W-1:0];
    s_code   = {acc_mode == 2'b10, acc_sel[IDX_W]};
    s_now    = ptr_w[s_idx];
    s_raw    = step_w[s_idx][FLD_W*int'(s_code) +: FLD_W];
    s_next   = s_now + {{(PTR_W-FLD_W){s_raw[FLD_W-1]}}, s_raw};
    s_ld_hit = ptr_ld_en && ptr_ld_idx == s_idx;
    f_mask   = {{(PTR_W-FLD_W){1'b0}}, {FLD_W{1'b1}}} << (FLD_W*int'(fld_code));
  end

  // R2 / R3: valid flag follows any access request
  p_vld_a_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_mode != 2'b00) |=> addr_a_vld);

  // R9: idle leaves port A flag low
  p_idle_vld_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_mode == 2'b00) |=> (!addr_a_vld && !addr_b_vld));

  // R2: source access returns old pointer
  p_src_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_mode == 2'b01) |=> (addr_a == $past(s_now)));

  // R2 / R4: source post-modify by sign-extended field
  p_src_upd_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_mode == 2'b01 && !s_ld_hit) |=> (ptr_w[$past(s_idx)] == $past(s_next)));

  // R3: destination post-modify by destination field
  p_dst_upd_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_mode == 2'b10 && !s_ld_hit) |=> (ptr_w[$past(s_idx)] == $past(s_next)));

  // R5: dual second address is the last pointer
  p_dual_b_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_mode == 2'b11) |=> (addr_b_vld && addr_b == $past(ptr_w[NPTR-1])));

  p_nodual_b_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_mode != 2'b11) |=> !addr_b_vld);

  for (genvar g = 0; g < NPTR; g++) begin : g_chk
    // R8 / R7: a pointer load always lands
    p_ld_wins_r8: assert property (@(posedge clk) disable iff (rst)
      (ptr_ld_en && ptr_ld_idx == IDX_W'(g)) |=> (ptr_w[g] == $past(ptr_ld_val)));

    // R7: full step load lands
    p_step_ld_r7: assert property (@(posedge clk) disable iff (rst)
      (step_ld_en && step_ld_idx == IDX_W'(g)) |=> (step_w[g] == $past(step_ld_val)));

    // R9: idle pointers hold
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (acc_mode == 2'b00 && !(ptr_ld_en && ptr_ld_idx == IDX_W'(g))) |=> $stable(ptr_w[g]));

    // R6: set-field touches only its field and writes the immediate
    p_fld_only_r6: assert property (@(posedge clk) disable iff (rst)
      (fld_en && fld_idx == IDX_W'(g) && !(step_ld_en && step_ld_idx == IDX_W'(g)))
      |=> (((step_w[g] ^ $past(step_w[g])) & ~$past(f_mask)) == '0
           && step_w[g][FLD_W*int'($past(fld_code)) +: FLD_W] == $past(fld_imm)));
  end

endmodule

bind postmod_ptr_unit pmp_checker #(.PTR_W(PTR_W), .NPTR(NPTR)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .acc_mode    (acc_mode),
  .acc_sel     (acc_sel),
  .ptr_ld_en   (ptr_ld_en),
  .ptr_ld_idx  (ptr_ld_idx),
  .ptr_ld_val  (ptr_ld_val),
  .step_ld_en  (step_ld_en),
  .step_ld_idx (step_ld_idx),
  .step_ld_val (step_ld_val),
  .fld_en      (fld_en),
  .fld_idx     (fld_idx),
  .fld_code    (fld_code),
  .fld_imm     (fld_imm),
  .addr_a      (addr_a),
  .addr_a_vld  (addr_a_vld),
  .addr_b      (addr_b),
  .addr_b_vld  (addr_b_vld),
  .ptr_flat    (ptr_flat),
  .step_flat   (step_flat)
);

// File: tb/postmod_ptr_unit_test.sv
`timescale 1ns/1ps
module postmod_ptr_unit_test;

  localparam int PTR_W = 16;
  localparam int NPTR  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  acc_mode = '0;
  logic [2:0]  acc_sel = '0;
  logic        ptr_ld_en = 1'b0;
  logic [1:0]  ptr_ld_idx = '0;
  logic [15:0] ptr_ld_val = '0;
  logic        step_ld_en = 1'b0;
  logic [1:0]  step_ld_idx = '0;
  logic [15:0] step_ld_val = '0;
  logic        fld_en = 1'b0;
  logic [1:0]  fld_idx = '0;
  logic [1:0]  fld_code = '0;
  logic [3:0]  fld_imm = '0;
  logic [15:0] addr_a, addr_b;
  logic        addr_a_vld, addr_b_vld;
  logic [63:0] ptr_flat, step_flat;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  postmod_ptr_unit #(.PTR_W(PTR_W), .NPTR(NPTR)) uut (
    .clk(clk), .rst(rst), .acc_mode(acc_mode), .acc_sel(acc_sel),
    .ptr_ld_en(ptr_ld_en), .ptr_ld_idx(ptr_ld_idx), .ptr_ld_val(ptr_ld_val),
    .step_ld_en(step_ld_en), .step_ld_idx(step_ld_idx), .step_ld_val(step_ld_val),
    .fld_en(fld_en), .fld_idx(fld_idx), .fld_code(fld_code), .fld_imm(fld_imm),
    .addr_a(addr_a), .addr_a_vld(addr_a_vld), .addr_b(addr_b), .addr_b_vld(addr_b_vld),
    .ptr_flat(ptr_flat), .step_flat(step_flat)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [2:0]  sel;
    logic        lp_en;
    logic [1:0]  lp_idx;
    logic [15:0] lp_val;
    logic        ls_en;
    logic [1:0]  ls_idx;
    logic [15:0] ls_val;
    logic        sf_en;
    logic [1:0]  sf_idx;
    logic [1:0]  sf_code;
    logic [3:0]  sf_imm;
    logic        ea_v;
    logic [15:0] ea;
    logic        eb_v;
    logic [15:0] eb;
    logic [1:0]  ci;
    logic [15:0] ep;
    logic [7:0]  req;
  } vec_t;

  function automatic vec_t mk(
    logic [1:0] mode, logic [2:0] sel,
    logic lp_en, logic [1:0] lp_idx, logic [15:0] lp_val,
    logic ls_en, logic [1:0] ls_idx, logic [15:0] ls_val,
    logic sf_en, logic [1:0] sf_idx, logic [1:0] sf_code, logic [3:0] sf_imm,
    logic ea_v, logic [15:0] ea, logic eb_v, logic [15:0] eb,
    logic [1:0] ci, logic [15:0] ep, logic [7:0] req);
    return '{mode, sel, lp_en, lp_idx, lp_val, ls_en, ls_idx, ls_val,
             sf_en, sf_idx, sf_code, sf_imm, ea_v, ea, eb_v, eb, ci, ep, req};
  endfunction

  localparam int NV = 23;
  // mode: 0 idle, 1 source, 2 destination, 3 dual
  localparam vec_t VECS [NV] = '{
    mk(0, 3'b000, 1, 0, 16'h0100, 1, 0, 16'hF321, 0, 0, 0, 0, 0, 0, 0, 0, 0, 16'h0100, 7),  // R7
    mk(0, 3'b000, 1, 1, 16'hFFFE, 1, 1, 16'h87E4, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'hFFFE, 7),  // R7
    mk(0, 3'b000, 1, 3, 16'h2000, 1, 3, 16'h2695, 0, 0, 0, 0, 0, 0, 0, 0, 3, 16'h2000, 7),  // R7
    mk(1, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0100, 0, 0, 0, 16'h0101, 2),         // R2 S0
    mk(1, 3'b100, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0101, 0, 0, 0, 16'h0103, 2),         // R2 S1
    mk(2, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0103, 0, 0, 0, 16'h0106, 3),         // R3 D0
    mk(2, 3'b100, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0106, 0, 0, 0, 16'h0105, 4),         // R4 -1
    mk(1, 3'b001, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'hFFFE, 0, 0, 1, 16'h0002, 4),         // R4 wrap
    mk(1, 3'b101, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0002, 0, 0, 1, 16'h0000, 4),         // R4 -2
    mk(2, 3'b101, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0000, 0, 0, 1, 16'hFFF8, 4),         // R4 -8
    mk(3, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0105, 1, 16'h2000, 0, 16'h0106, 5),  // R5
    mk(3, 3'b111, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'hFFF8, 1, 16'h2005, 3, 16'h1FFE, 5),  // R5
    mk(0, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'hFFF6, 9),                // R9
    mk(0, 3'b000, 0, 0, 0, 0, 0, 0, 1, 0, 2'b11, 4'h2, 0, 0, 0, 0, 0, 16'h0106, 6),         // R6
    mk(2, 3'b100, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0106, 0, 0, 0, 16'h0108, 6),         // R6
    mk(1, 3'b000, 0, 0, 0, 0, 0, 0, 1, 0, 2'b00, 4'h7, 1, 16'h0108, 0, 0, 0, 16'h0109, 10), // R10
    mk(1, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0109, 0, 0, 0, 16'h0110, 6),         // R6
    mk(1, 3'b010, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0000, 0, 0, 2, 16'h0000, 2),         // R2
    mk(1, 3'b011, 1, 3, 16'h4000, 0, 0, 0, 0, 0, 0, 0, 1, 16'h1FFE, 0, 0, 3, 16'h4000, 8),  // R8
    mk(3, 3'b000, 1, 0, 16'h0500, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0110, 1, 16'h4000, 0, 16'h0500, 8), // R8
    mk(0, 3'b000, 0, 0, 0, 1, 2, 16'h1111, 1, 2, 2'b00, 4'hF, 0, 0, 0, 0, 3, 16'h4005, 5),  // R5
    mk(1, 3'b010, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0000, 0, 0, 2, 16'h0001, 7),         // R7
    mk(3, 3'b001, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'hFFF6, 1, 16'h4005, 1, 16'hFFFA, 5)   // R5
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic idle_inputs();
    acc_mode = '0; acc_sel = '0;
    ptr_ld_en = 1'b0; step_ld_en = 1'b0; fld_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state after reset
    check("R1", "ptrs", ptr_flat, 64'h0);
    check("R1", "steps", step_flat, 64'h0);
    check("R1", "vld", {62'h0, addr_a_vld, addr_b_vld}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      acc_mode    = VECS[i].mode;
      acc_sel     = VECS[i].sel;
      ptr_ld_en   = VECS[i].lp_en;
      ptr_ld_idx  = VECS[i].lp_idx;
      ptr_ld_val  = VECS[i].lp_val;
      step_ld_en  = VECS[i].ls_en;
      step_ld_idx = VECS[i].ls_idx;
      step_ld_val = VECS[i].ls_val;
      fld_en      = VECS[i].sf_en;
      fld_idx     = VECS[i].sf_idx;
      fld_code    = VECS[i].sf_code;
      fld_imm     = VECS[i].sf_imm;
      @(negedge clk);
      check(tag, $sformatf("vec%0d a_vld", i), {63'h0, addr_a_vld}, {63'h0, VECS[i].ea_v});
      check(tag, $sformatf("vec%0d b_vld", i), {63'h0, addr_b_vld}, {63'h0, VECS[i].eb_v});
      if (VECS[i].ea_v) check(tag, $sformatf("vec%0d addr_a", i), {48'h0, addr_a}, {48'h0, VECS[i].ea});
      if (VECS[i].eb_v) check(tag, $sformatf("vec%0d addr_b", i), {48'h0, addr_b}, {48'h0, VECS[i].eb});
      check(tag, $sformatf("vec%0d ptr", i),
            {48'h0, ptr_flat[16*VECS[i].ci +: 16]}, {48'h0, VECS[i].ep});
    end
    idle_inputs();
    @(negedge clk);

    // R6 / R10: step 0 after D1<-2 and S0<-7
    check("R6", "step0 fields", {48'h0, step_flat[15:0]}, 64'h2327);
    // R7: full step load beat same-cycle set-field
    check("R7", "step2 load wins", {48'h0, step_flat[47:32]}, 64'h1111);
    // R5: last pointer after two dual accesses since its load
    check("R5", "ptr3", {48'h0, ptr_flat[63:48]}, 64'h400A);
    // R9: idle cycle keeps flags low
    check("R9", "idle flags", {62'h0, addr_a_vld, addr_b_vld}, 64'h0);

    // R1: reset in the middle of activity
    acc_mode = 2'b11;
    rst = 1'b1;
    @(negedge clk);
    idle_inputs();
    rst = 1'b0;
    check("R1", "ptrs after reset", ptr_flat, 64'h0);
    check("R1", "steps after reset", step_flat, 64'h0);
    check("R1", "addr after reset", {addr_a, addr_b, 30'h0, addr_a_vld, addr_b_vld}, 64'h0);
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

endmodule